// File: doc/BRIEF.md
# JTAG Shift-and-Verify Stream Player

This block takes commands as a byte stream over a ready/valid interface and turns them into JTAG pin activity on a scan chain. It drives the test clock, the mode select and the data-in pin, and it samples data-out. It handles two commands. The first is a shift-with-verify command. It clocks stimulus bits into the chain and compares each returned bit against an expected value wherever a compare mask allows. The second is a run-idle command, which pulses the test clock a requested number of times with mode select held low.

A verify command carries no stored copy of the whole expected response. Stimulus, expected data and mask arrive interleaved one byte at a time, so the comparison runs as the bits come back. Only one byte of each kind is held at any time. The test clock is derived from the system clock by a programmable divider. The engine stops accepting bytes while bits are being clocked, and the test clock rests low between bits and commands.

Top module: `jtag_verify_player`

## Requirements
- R1: Opcode byte 0x04 starts a shift-with-verify command. It is followed by a 32-bit bit count sent least significant byte first. The payload that follows is a sequence of triplets, each made of a stimulus byte, then an expected-response byte, then a mask byte.
- R2: A shift command with count N produces exactly N rising edges of `tck`. Bit i of the command drives `tdi` with bit (i mod 8) of stimulus byte (i div 8), so each byte is sent least significant bit first.
- R3: During a shift, `tms` is 0 at every rising edge of `tck` except the last bit of the command, where it is 1.
- R4: A returned bit counts as a mismatch only when its mask bit is 1 and the value of `tdo` at the rising edge differs from the expected bit. `fail` goes to 1 on the first mismatch and stays there. `fail_index` holds the 0-based position, within the command, of the first mismatching bit. Both clear when the next 0x04 opcode is accepted.
- R5: When N is not a multiple of 8, the final triplet uses only its low N mod 8 bits. The remaining stimulus, expected and mask bits cause no `tck` edge and no mismatch.
- R6: Opcode byte 0x07, followed by a 32-bit count sent least significant byte first, produces exactly that many `tck` pulses with `tms` and `tdi` at 0. It leaves `fail` and `fail_index` unchanged.
- R7: `done` is a single-cycle pulse raised after the last bit of either command. A count of 0 raises `done` without any `tck` pulse.
- R8: `in_ready` is 0 whenever `tck` is high and while bits are being clocked. It is 1 while the engine waits for an opcode, count byte or payload byte.
- R9: Each `tck` high phase lasts exactly `clk_div`+1 system clock cycles, and each low phase lasts at least that long. `tdi` and `tms` change only while `tck` is low.
- R10: Opcode bytes other than 0x04 and 0x07 are consumed and ignored. They produce no `tck` edge and no `done`.
- R11: After reset, `tck`, `tms`, `tdi`, `done` and `fail` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Test clock half-period minus one, in system cycles |
| in_valid | input | 1 | Command byte valid |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the chain |
| tdo | input | 1 | Test data from the chain |
| done | output | 1 | One-cycle pulse at the end of a command |
| fail | output | 1 | Sticky mismatch flag for the last verify command |
| fail_index | output | CNT_W | Bit position of the first mismatch |

## Verification
The bench builds the block with the full 32-bit count field and a 4-bit divider, and drives `clk_div` only from 0 to 3. The value 0 gives single-cycle clock phases, where a new bit is issued right after the previous falling edge and the sample happens on the same edge that raises `tck`. The small range keeps each test clock period short, so the bench can run many commands with random lengths of up to six triplets. That covers partial final triplets, lengths that are exact multiples of 8, and zero-length commands.

// File: rtl/jvp_pkg.sv
package jvp_pkg;

    localparam logic [7:0] OP_SHIFT_VERIFY = 8'h04;
    localparam logic [7:0] OP_RUN_IDLE     = 8'h07;
    localparam int         BYTE_BITS       = 8;

    typedef enum logic [2:0] {
        S_OPCODE,
        S_COUNT,
        S_STIM,
        S_EXPECT,
        S_MASK,
        S_SHIFT,
        S_RUN
    } seq_state_e;

endpackage

// File: rtl/jvp_tck_gen.sv
// One test-clock period per request: low phase, rising edge with sample, high phase.
module jvp_tck_gen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             start,
    input  logic             tdi_in,
    input  logic             tms_in,
    input  logic             tdo,
    output logic             tck,
    output logic             tdi,
    output logic             tms,
    output logic             bit_done,
    output logic             tdo_bit
);

    typedef struct packed {
        logic             active;
        logic             high;
        logic [DIV_W-1:0] cnt;
        logic             tck;
        logic             tdi;
        logic             tms;
        logic             smp;
        logic             done;
    } gen_t;

    gen_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.active) begin
            if (start) begin
                d.active = 1'b1;
                d.high   = 1'b0;
                d.cnt    = div;
                d.tdi    = tdi_in;
                d.tms    = tms_in;
            end
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end else if (!q.high) begin
            d.high = 1'b1;
            d.tck  = 1'b1;
            d.smp  = tdo;
            d.cnt  = div;
        end else begin
            d.high   = 1'b0;
            d.tck    = 1'b0;
            d.active = 1'b0;
            d.done   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tck      = q.tck;
    assign tdi      = q.tdi;
    assign tms      = q.tms;
    assign bit_done = q.done;
    assign tdo_bit  = q.smp;

endmodule

// File: rtl/jvp_seq.sv
// Command parser and bit sequencer.
module jvp_seq
    import jvp_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       bit_start,
    output logic       bit_tdi,
    output logic       bit_tms,
    input  logic       bit_done,
    output logic       cmp_valid,
    output logic       cmp_exp,
    output logic       cmp_msk,
    output logic       cmd_clear,
    output logic       done
);

    localparam int CNT_BYTES = CNT_W / BYTE_BITS;
    localparam int BI_W      = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1;
    localparam int BP_W      = $clog2(BYTE_BITS);

    typedef struct packed {
        seq_state_e      state;
        logic            is_run;
        logic [CNT_W-1:0] cnt;
        logic [BI_W-1:0] bidx;
        logic [CNT_W-1:0] rem;
        logic [BP_W-1:0] bitpos;
        logic [7:0]      stim;
        logic [7:0]      expv;
        logic [7:0]      mask;
        logic            issued;
        logic            done;
    } seq_t;

    seq_t q, d;
    logic accept;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        in_ready  = (q.state != S_SHIFT) && (q.state != S_RUN);
        accept    = in_valid && in_ready;
        bit_start = 1'b0;
        bit_tdi   = 1'b0;
        bit_tms   = 1'b0;
        cmd_clear = 1'b0;
        cmp_valid = (q.state == S_SHIFT) && q.issued && bit_done;
        cmp_exp   = q.expv[q.bitpos];
        cmp_msk   = q.mask[q.bitpos];

        case (q.state)
            S_OPCODE: begin
                if (accept) begin
                    d.bidx = '0;
                    if (in_data == OP_SHIFT_VERIFY) begin
                        cmd_clear = 1'b1;
                        d.is_run  = 1'b0;
                        d.state   = S_COUNT;
                    end else if (in_data == OP_RUN_IDLE) begin
                        d.is_run  = 1'b1;
                        d.state   = S_COUNT;
                    end
                end
            end
            S_COUNT: begin
                if (accept) begin
                    d.cnt  = (q.cnt >> BYTE_BITS) | (CNT_W'(in_data) << (CNT_W - BYTE_BITS));
                    d.bidx = q.bidx + 1'b1;
                    if (q.bidx == BI_W'(CNT_BYTES - 1)) begin
                        d.rem    = d.cnt;
                        d.issued = 1'b0;
                        if (d.cnt == '0) begin
                            d.done  = 1'b1;
                            d.state = S_OPCODE;
                        end else begin
                            d.state = q.is_run ? S_RUN : S_STIM;
                        end
                    end
                end
            end
            S_STIM: begin
                if (accept) begin
                    d.stim  = in_data;
                    d.state = S_EXPECT;
                end
            end
            S_EXPECT: begin
                if (accept) begin
                    d.expv  = in_data;
                    d.state = S_MASK;
                end
            end
            S_MASK: begin
                if (accept) begin
                    d.mask   = in_data;
                    d.bitpos = '0;
                    d.state  = S_SHIFT;
                end
            end
            S_SHIFT: begin
                if (!q.issued) begin
                    bit_start = 1'b1;
                    bit_tdi   = q.stim[q.bitpos];
                    bit_tms   = (q.rem == CNT_W'(1));
                    d.issued  = 1'b1;
                end else if (bit_done) begin
                    d.issued = 1'b0;
                    d.rem    = q.rem - 1'b1;
                    d.bitpos = q.bitpos + 1'b1;
                    if (q.rem == CNT_W'(1)) begin
                        d.done  = 1'b1;
                        d.state = S_OPCODE;
                    end else if (q.bitpos == BP_W'(BYTE_BITS - 1)) begin
                        d.state = S_STIM;
                    end
                end
            end
            S_RUN: begin
                if (!q.issued) begin
                    bit_start = 1'b1;
                    d.issued  = 1'b1;
                end else if (bit_done) begin
                    d.issued = 1'b0;
                    d.rem    = q.rem - 1'b1;
                    if (q.rem == CNT_W'(1)) begin
                        d.done  = 1'b1;
                        d.state = S_OPCODE;
                    end
                end
            end
            default: d.state = S_OPCODE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_OPCODE;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;

endmodule

// File: rtl/jvp_verify.sv
// Masked on-the-fly compare with sticky first-failure capture.
module jvp_verify #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             cmp_valid,
    input  logic             tdo_bit,
    input  logic             exp_bit,
    input  logic             msk_bit,
    output logic             fail,
    output logic [CNT_W-1:0] fail_index
);

    typedef struct packed {
        logic             fail;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] pos;
    } ver_t;

    ver_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d = '0;
        end else if (cmp_valid) begin
            d.pos = q.pos + 1'b1;
            if (msk_bit && (tdo_bit != exp_bit) && !q.fail) begin
                d.fail = 1'b1;
                d.idx  = q.pos;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fail       = q.fail;
    assign fail_index = q.idx;

endmodule

// File: rtl/jtag_verify_player.sv
module jtag_verify_player #(
    parameter int DIV_W = 4,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    input  logic             tdo,
    output logic             done,
    output logic             fail,
    output logic [CNT_W-1:0] fail_index
);

    logic bit_start, bit_tdi, bit_tms, bit_done, tdo_bit;
    logic cmp_valid, cmp_exp, cmp_msk, cmd_clear;

    jvp_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .bit_start (bit_start),
        .bit_tdi   (bit_tdi),
        .bit_tms   (bit_tms),
        .bit_done  (bit_done),
        .cmp_valid (cmp_valid),
        .cmp_exp   (cmp_exp),
        .cmp_msk   (cmp_msk),
        .cmd_clear (cmd_clear),
        .done      (done)
    );

    jvp_tck_gen #(.DIV_W(DIV_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .div      (clk_div),
        .start    (bit_start),
        .tdi_in   (bit_tdi),
        .tms_in   (bit_tms),
        .tdo      (tdo),
        .tck      (tck),
        .tdi      (tdi),
        .tms      (tms),
        .bit_done (bit_done),
        .tdo_bit  (tdo_bit)
    );

    jvp_verify #(.CNT_W(CNT_W)) u_ver (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (cmd_clear),
        .cmp_valid  (cmp_valid),
        .tdo_bit    (tdo_bit),
        .exp_bit    (cmp_exp),
        .msk_bit    (cmp_msk),
        .fail       (fail),
        .fail_index (fail_index)
    );

endmodule

// File: rtl/jvp_checker.sv
module jvp_checker #(
    parameter int DIV_W = 4,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] clk_div,
    input logic             in_valid,
    input logic [7:0]       in_data,
    input logic             in_ready,
    input logic             tck,
    input logic             tms,
    input logic             tdi,
    input logic             done,
    input logic             fail,
    input logic [CNT_W-1:0] fail_index
);

    // R8: no byte is taken while the test clock is high
    p_ready_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tck |-> !in_ready);

    // R9: pins hold still through the high phase and at the rising edge
    p_pins_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tck |-> ($stable(tdi) && $stable(tms)));

    // R7: done lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: fail stays set unless a byte is accepted that may be a new verify opcode
    p_fail_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(in_valid && in_ready && in_data == 8'h04)) |=> fail);

    // R4: first failing index never moves while fail stays set
    p_index_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && $past(fail)) |-> $stable(fail_index));

    // R7: done never coincides with a high test clock
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !tck);

endmodule

bind jtag_verify_player jvp_checker #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_div    (clk_div),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .tck        (tck),
    .tms        (tms),
    .tdi        (tdi),
    .done       (done),
    .fail       (fail),
    .fail_index (fail_index)
);

// File: tb/tb_jtag_verify_player.sv
module tb_jtag_verify_player;

    localparam int DIV_W = 4;
    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [DIV_W-1:0] clk_div;
    logic             in_valid;
    logic [7:0]       in_data;
    logic             in_ready, tck, tms, tdi, tdo, done, fail;
    logic [CNT_W-1:0] fail_index;

    always #4 clk = ~clk;

    jtag_verify_player #(.DIV_W(DIV_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .tck(tck), .tms(tms), .tdi(tdi),
        .tdo(tdo), .done(done), .fail(fail), .fail_index(fail_index)
    );

    int  errors = 0;
    int  checks = 0;
    bit  resp    [0:1023];
    bit  cap_tdi [0:1023];
    bit  cap_tms [0:1023];
    int  k = 0;
    int  hi_run = 0;
    int  hi_bad = 0;
    int  rdy_bad = 0;
    int  done_cnt = 0;
    int  cycles = 0;

    assign tdo = resp[k[9:0]];

    // chain model: record pins at each rising test-clock edge, then advance the response
    always @(posedge tck) begin
        cap_tdi[k[9:0]] = tdi;
        cap_tms[k[9:0]] = tms;
        k = k + 1;
    end

    always @(negedge clk) begin
        if (tck) hi_run++;
        else if (hi_run != 0) begin
            if (hi_run != int'(clk_div) + 1) hi_bad++;
            hi_run = 0;
        end
        if (tck && in_ready) rdy_bad++;
        if (done) done_cnt++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic send_count(input int n);
        for (int i = 0; i < 4; i++) send_byte(8'((n >> (8 * i)) & 8'hff));
    endtask

    task automatic wait_done(output bit seen);
        int start = done_cnt;
        seen = 1'b0;
        for (int t = 0; t < 20000; t++) begin
            @(negedge clk);
            #1;
            if (done_cnt != start) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    // mode 0: sparse random mismatches, 1: all match, 2: all differ but mask 0,
    // 3: mismatches only in unused tail bits, 4: all differ with full mask
    task automatic run_shift(input int nbits, input int mode);
        logic [7:0] st [0:15];
        logic [7:0] ex [0:15];
        logic [7:0] mk [0:15];
        int  nbytes = (nbits + 7) / 8;
        bit  efail = 1'b0;
        int  eidx = 0;
        bit  seen;
        int  tdi_bad = 0;
        int  tms_bad = 0;
        for (int i = 0; i < 128; i++) resp[i] = 1'($urandom);
        for (int b = 0; b < nbytes; b++) begin
            st[b] = 8'($urandom);
            mk[b] = 8'($urandom);
            if (mode >= 2) mk[b] = (mode == 2) ? 8'h00 : 8'hff;
            for (int j = 0; j < 8; j++) begin
                int  p = b * 8 + j;
                bit  e = resp[p];
                if (mode == 0 && ($urandom % 12) == 0) e = !e;
                if (mode == 2 || mode == 4) e = !e;
                if (mode == 3 && p >= nbits) e = !e;
                ex[b][j] = e;
                if (p < nbits && !efail && mk[b][j] && (e != resp[p])) begin
                    efail = 1'b1;
                    eidx  = p;
                end
            end
        end
        k = 0;
        hi_bad = 0;
        rdy_bad = 0;
        send_byte(8'h04);
        send_count(nbits);
        for (int b = 0; b < nbytes; b++) begin
            send_byte(st[b]);
            send_byte(ex[b]);
            send_byte(mk[b]);
        end
        wait_done(seen);
        chk(seen, "R7 done after shift", longint'(seen), 1);
        chk(k == nbits, "R2/R5 tck edge count", k, nbits);
        for (int i = 0; i < nbits; i++) begin
            if (cap_tdi[i] != st[i / 8][i % 8]) tdi_bad++;
            if (cap_tms[i] != (i == nbits - 1)) tms_bad++;
        end
        chk(tdi_bad == 0, "R2 tdi bit order", tdi_bad, 0);
        chk(tms_bad == 0, "R3 tms pattern", tms_bad, 0);
        chk(fail == efail, "R4 fail flag", longint'(fail), longint'(efail));
        if (efail) chk(fail_index == CNT_W'(eidx), "R4 first fail index", fail_index, eidx);
        chk(hi_bad == 0, "R9 tck high length", hi_bad, 0);
        chk(rdy_bad == 0, "R8 ready while clocking", rdy_bad, 0);
    endtask

    task automatic run_idle(input int n);
        bit seen;
        bit pf = fail;
        logic [CNT_W-1:0] pi = fail_index;
        int bad = 0;
        k = 0;
        send_byte(8'h07);
        send_count(n);
        wait_done(seen);
        chk(seen, "R7 done after run-idle", longint'(seen), 1);
        chk(k == n, "R6 run-idle pulses", k, n);
        for (int i = 0; i < n; i++) if (cap_tms[i] || cap_tdi[i]) bad++;
        chk(bad == 0, "R6 tms/tdi low", bad, 0);
        chk(fail == pf && fail_index == pi, "R6 fail untouched", longint'(fail), longint'(pf));
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_data = 8'h00;
        clk_div = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!tck && !tms && !tdi, "R11 pins low in reset", {tck, tms, tdi}, 0);
        chk(!done && !fail && in_ready, "R11 flags after reset", {done, fail, in_ready}, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 exact byte, R4 full-mask mismatch at bit 0
        run_shift(8, 1);
        run_shift(1, 4);
        run_idle(5);               // R6 fail must stay set
        run_shift(13, 3);          // R5 unused tail bits ignored
        run_shift(12, 2);          // R4 mask 0 hides mismatches
        begin
            bit seen;
            int dc = done_cnt;
            k = 0;
            send_byte(8'h04);
            send_count(0);
            wait_done(seen);
            chk(seen && k == 0, "R7 zero-length shift", k, 0);
            chk(!fail, "R4 cleared by new opcode", longint'(fail), 0);
            k = 0;
            dc = done_cnt;
            send_byte(8'hA3);
            send_byte(8'h00);
            repeat (10) @(negedge clk);
            chk(k == 0 && done_cnt == dc && in_ready, "R10 unknown opcode ignored", k, 0);
        end
        run_idle(0);
        clk_div = 4'd3;
        run_shift(20, 0);
        run_idle(3);

        for (int it = 0; it < 30; it++) begin
            clk_div = DIV_W'($urandom % 4);
            if (($urandom % 5) == 0) run_idle(1 + int'($urandom % 9));
            else run_shift(1 + int'($urandom % 48), int'($urandom % 5));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule